// File: doc/BRIEF.md
# Character Parity Generator and Checker

This block guards one nine-bit memory character as it is written or moved. The six low bits carry the data value and its two zone bits, the next two bits are punctuation marks that bound fields and items, and the top bit is the parity bit. The caller presents a character on `char_in` with the `char_vld` strobe and chooses an operation. A generate operation replaces the parity bit so that the character holds an odd count of ones. A check operation passes the character through untouched and flags it when its count of ones is even.

A runtime input `punct_cnt` sets which positions take part. With it low, only the six data bits and the parity bit are counted, and the punctuation bits are ignored. With it high, the two punctuation bits are counted as well. Each result is registered and appears one clock after the strobe. A sticky flag records any check failure until software-independent control logic pulses `err_clr`.

Top module: `char_parity_unit`

## Requirements
- R1: One cycle after a clock edge that samples `char_vld` high, `res_vld` is high and `res_char[7:0]` equals the sampled `char_in[7:0]`; when `char_vld` was low, `res_vld` is low and `res_char` keeps its previous value.
- R2: Generate (`op_sel` = 0) with `punct_cnt` = 0: `res_char[8]` is 1 exactly when `char_in[5:0]` holds an even number of ones; `char_in[7:6]` and the incoming `char_in[8]` have no effect on it.
- R3: Generate with `punct_cnt` = 1: `res_char[8]` is 1 exactly when `char_in[7:0]` holds an even number of ones, so `res_char[8:0]` always holds an odd count.
- R4: Check (`op_sel` = 1) with `punct_cnt` = 0: `res_err` is 1 exactly when `char_in[5:0]` together with `char_in[8]` hold an even number of ones; bits 7:6 have no effect.
- R5: Check with `punct_cnt` = 1: `res_err` is 1 exactly when all nine bits of `char_in` hold an even number of ones.
- R6: A check returns the character unchanged, including bit 8.
- R7: A generate operation never raises `res_err`.
- R8: `res_err` is low in every cycle in which `res_vld` is low.
- R9: `err_seen` goes high in the same cycle as `res_err` and stays high until cleared.
- R10: `err_clr` high at a clock edge clears `err_seen`, unless that same edge also registers a new check failure, in which case `err_seen` stays high.
- R11: After synchronous reset (`rst_n` low at a clock edge) `res_vld`, `res_char`, `res_err` and `err_seen` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| char_vld | input | 1 | Character strobe |
| op_sel | input | 1 | 0 = generate parity, 1 = check parity |
| punct_cnt | input | 1 | 0 = data bits only, 1 = data and punctuation bits counted |
| char_in | input | 9 | Character: [5:0] data, [6] word mark, [7] item mark, [8] parity |
| err_clr | input | 1 | Clears the sticky error flag |
| res_vld | output | 1 | Result strobe, one cycle after `char_vld` |
| res_char | output | 9 | Character with generated or passed-through parity |
| res_err | output | 1 | Check failure for the current result |
| err_seen | output | 1 | Sticky check-failure flag |

## Verification
Every result of this block, the character, its parity bit, the per-character error and the sticky flag, is due exactly one clock edge after the strobe that carried the stimulus, and a clear acts on that same edge. The bench drives each stimulus on a falling edge and samples all four outputs on the following falling edge, so exactly one rising edge separates them. Its reference model computes the expected parity and error from the bit positions and mode alone, and carries the sticky flag forward by the set-over-clear rule.

// File: rtl/cpg_pkg.sv
// Shared widths and encodings for the character parity unit.
// Assumes the character is data bits, then punctuation bits, then one parity bit on top.
package cpg_pkg;
    localparam int DATA_BITS  = 6;
    localparam int PUNCT_BITS = 2;

    typedef enum logic {
        OP_GEN = 1'b0,
        OP_CHK = 1'b1
    } op_e;

    typedef enum logic {
        CNT_DATA_ONLY = 1'b0,
        CNT_WITH_MARK = 1'b1
    } cnt_e;
endpackage

// File: rtl/cpg_xor_chain.sv
// Odd-parity detector: odd_o is 1 when bits_i holds an odd number of ones.
// Assumes W >= 1; built as a generate chain so the width follows the parameter.
module cpg_xor_chain #(
    parameter int W = 8
) (
    input  logic [W-1:0] bits_i,
    output logic         odd_o
);
    logic [W:0] acc;

    assign acc[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_stage
        // one stage: fold in bit i
        assign acc[i+1] = acc[i] ^ bits_i[i];
    end

    assign odd_o = acc[W];
endmodule

// File: rtl/cpg_select.sv
// Picks which body bits take part in the count: data always, punctuation only when enabled.
// Assumes body is {punctuation, data} with data in the low bits.
module cpg_select #(
    parameter int DATA_W  = 6,
    parameter int PUNCT_W = 2,
    localparam int BODY_W = DATA_W + PUNCT_W
) (
    input  logic [BODY_W-1:0] body_i,
    input  logic              with_mark_i,
    output logic [BODY_W-1:0] counted_o
);
    // data passes always, punctuation bits gated by the mode
    always_comb begin
        counted_o = body_i;
        for (int k = DATA_W; k < BODY_W; k++) begin
            counted_o[k] = body_i[k] & with_mark_i;
        end
    end
endmodule

// File: rtl/cpg_sticky.sv
// Sticky error flag: set wins over clear on the same edge.
// Assumes set_i and clr_i are sampled on the rising clock edge; synchronous active-low reset.
module cpg_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // hold, clear or set the flag
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    // R10: a clear with no new failure empties the flag
    p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

    // R9: a flagged failure stays until a clear arrives
    p_flag_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/char_parity_unit.sv
// Parity generator and checker for one nine-bit character per cycle.
// Generate replaces the parity bit so the counted positions are odd; check passes the
// character and flags an even count. Results are registered one cycle after the strobe.
// Assumes op_sel and punct_cnt are qualified by char_vld.
module char_parity_unit #(
    parameter int DATA_W  = cpg_pkg::DATA_BITS,
    parameter int PUNCT_W = cpg_pkg::PUNCT_BITS,
    localparam int BODY_W = DATA_W + PUNCT_W,
    localparam int CHAR_W = BODY_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_vld,
    input  logic              op_sel,
    input  logic              punct_cnt,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              err_clr,
    output logic              res_vld,
    output logic [CHAR_W-1:0] res_char,
    output logic              res_err,
    output logic              err_seen
);
    import cpg_pkg::*;

    logic [BODY_W-1:0] body;
    logic [BODY_W-1:0] counted;
    logic              body_odd;
    logic              par_in;
    logic              is_chk;
    logic              gen_par;
    logic              chk_fail;
    logic              new_fail;
    logic [CHAR_W-1:0] next_char;

    assign body   = char_in[BODY_W-1:0];
    assign par_in = char_in[CHAR_W-1];
    assign is_chk = (op_e'(op_sel) == OP_CHK);

    cpg_select #(
        .DATA_W  (DATA_W),
        .PUNCT_W (PUNCT_W)
    ) u_select (
        .body_i      (body),
        .with_mark_i (cnt_e'(punct_cnt) == CNT_WITH_MARK),
        .counted_o   (counted)
    );

    cpg_xor_chain #(
        .W (BODY_W)
    ) u_chain (
        .bits_i (counted),
        .odd_o  (body_odd)
    );

    // parity bit that makes the counted positions odd; failure when they are even
    always_comb begin
        gen_par   = ~body_odd;
        chk_fail  = ~(body_odd ^ par_in);
        next_char = is_chk ? char_in : {gen_par, body};
        new_fail  = char_vld & is_chk & chk_fail;
    end

    // result registers, loaded on a strobe; error is a one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld  <= 1'b0;
            res_char <= '0;
            res_err  <= 1'b0;
        end else begin
            res_vld <= char_vld;
            res_err <= new_fail;
            if (char_vld) res_char <= next_char;
        end
    end

    cpg_sticky u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (new_fail),
        .clr_i  (err_clr),
        .flag_o (err_seen)
    );

    // R1: result strobe follows the input strobe by one cycle
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_vld == $past(char_vld)));

    // R1: body bits are carried through unchanged
    p_body_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && res_vld) |-> (res_char[BODY_W-1:0] == $past(char_in[BODY_W-1:0])));

    // R3: generated character with marks counted holds odd parity over all bits
    p_gen_odd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && res_vld && $past(op_sel) == 1'b0 && $past(punct_cnt))
        |-> ($countones(res_char) % 2 == 1));

    // R6: a check returns the parity bit it was given
    p_chk_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && res_vld && $past(op_sel)) |-> (res_char == $past(char_in)));

    // R7: generate never reports a failure
    p_gen_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && res_vld && !$past(op_sel)) |-> !res_err);

    // R8: no error without a result
    p_err_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> !res_err);

    // R9: sticky flag rises with the error pulse
    p_sticky_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_err |-> err_seen);
endmodule

// File: tb/char_parity_unit_tb.sv
module char_parity_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       char_vld, op_sel, punct_cnt, err_clr;
    logic [8:0] char_in;
    logic       res_vld, res_err, err_seen;
    logic [8:0] res_char;

    int n_tests = 0;
    int n_fail  = 0;

    logic [8:0] exp_char;
    logic       exp_sticky;

    always #10 clk = ~clk;

    char_parity_unit u_dut (
        .clk(clk), .rst_n(rst_n), .char_vld(char_vld), .op_sel(op_sel),
        .punct_cnt(punct_cnt), .char_in(char_in), .err_clr(err_clr),
        .res_vld(res_vld), .res_char(res_char), .res_err(res_err), .err_seen(err_seen)
    );

    function automatic logic f_gen_par(input logic [8:0] c, input logic m);
        int ones = 0;
        for (int i = 0; i < 6; i++) ones += c[i];
        if (m) ones += c[6] + c[7];
        return (ones % 2 == 0);
    endfunction

    function automatic logic f_chk_err(input logic [8:0] c, input logic m);
        int ones = 0;
        for (int i = 0; i < 6; i++) ones += c[i];
        ones += c[8];
        if (m) ones += c[6] + c[7];
        return (ones % 2 == 0);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive on current falling edge, check on next falling edge
    task automatic step(input logic v, input logic op, input logic m,
                        input logic [8:0] c, input logic clr, input string req);
        logic e_err;
        char_vld = v; op_sel = op; punct_cnt = m; char_in = c; err_clr = clr;
        e_err = v && op && f_chk_err(c, m);
        if (v) exp_char = op ? c : {f_gen_par(c, m), c[7:0]};
        exp_sticky = e_err ? 1'b1 : (clr ? 1'b0 : exp_sticky);
        @(negedge clk);
        check({req, " R1 vld"}, res_vld, v);
        check({req, " char R2/R3/R6"}, res_char, exp_char);
        check({req, " err R4/R5/R7/R8"}, res_err, e_err);
        check({req, " sticky R9/R10"}, err_seen, exp_sticky);
        char_vld = 1'b0; err_clr = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        process p;
        p = process::self();
        p.srandom(32'd1234);
        rst_n = 1'b0; char_vld = 1'b0; op_sel = 1'b0; punct_cnt = 1'b0;
        char_in = '0; err_clr = 1'b0;
        exp_char = '0; exp_sticky = 1'b0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 vld", res_vld, 0);
        check("R11 char", res_char, 0);
        check("R11 err", res_err, 0);
        check("R11 sticky", err_seen, 0);
        rst_n = 1'b1;

        // R2: all zero data, marks and incoming parity ignored
        step(1, 0, 0, 9'h000, 0, "R2 zero");
        check("R2 zero par", res_char, 9'h100);
        step(1, 0, 0, 9'h1C0, 0, "R2 marks ignored");
        check("R2 marks par", res_char, 9'h1C0);
        step(1, 0, 0, 9'h101, 0, "R2 odd data");
        check("R2 odd data par", res_char, 9'h001);
        // R3: marks counted
        step(1, 0, 1, 9'h0C0, 0, "R3 marks even");
        check("R3 par", res_char, 9'h1C0);
        step(1, 0, 1, 9'h040, 0, "R3 one mark");
        check("R3 par one", res_char, 9'h040);
        // R8: idle keeps char, no error
        step(0, 1, 0, 9'h000, 0, "R8 idle");
        check("R8 hold", res_char, 9'h040);
        // R4/R5
        step(1, 1, 0, 9'h100, 0, "R4 good");
        check("R4 good err", res_err, 0);
        step(1, 1, 0, 9'h040, 0, "R4 mark ignored");
        check("R4 bad err", res_err, 1);
        check("R9 set", err_seen, 1);
        step(1, 1, 1, 9'h040, 0, "R5 mark counted");
        check("R5 good err", res_err, 0);
        step(0, 0, 0, 9'h000, 0, "R9 hold");
        check("R9 hold", err_seen, 1);
        step(0, 0, 0, 9'h000, 1, "R10 clear");
        check("R10 cleared", err_seen, 0);
        step(1, 1, 1, 9'h0C0, 0, "R5 even all");
        check("R5 bad err", res_err, 1);
        step(1, 1, 0, 9'h000, 1, "R10 set wins");
        check("R10 set wins", err_seen, 1);
        step(0, 0, 0, 9'h000, 1, "R10 clear2");

        for (int it = 0; it < 400; it++) begin
            step(($urandom % 4) != 0, $urandom % 2, $urandom % 2,
                 9'($urandom), ($urandom % 10) == 0, "random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule